// File: doc/BRIEF.md
# USB Host Port Control and Status Register

This block holds the single 32-bit control and status word for one downstream port of a USB host controller. The port state machine and PHY side send it event pulses (device attached, device detached, port reset sequence finished) and levels (overcurrent, line state, negotiated speed). The block turns these into sticky change flags, a hardware-owned enable bit and mirrored status fields. Software owns a group of control fields (resume, suspend, port reset, port power, test control). The block drives those fields straight out to the port logic.

Software sees the whole word on a read bus and updates it with a full-word write strobe. The three change flags clear when software writes a 1 to them. The enable bit can be cleared the same way but never set by software. Firmware that does read-modify-write must therefore zero bits 1, 2, 3 and 5 before writing the word back. A single port interrupt line is high whenever any change flag is set.

Top module: `hport_csr`

## Requirements
- R1: After synchronous reset the read word is all zeros, every control output is low and the interrupt is low.
- R2: Bit 0 (connected) becomes 1 in the cycle after an attach pulse and 0 after a detach pulse (detach wins if both come together). Software writes to bit 0 have no effect.
- R3: Bit 1 (connect detected) is set by an attach pulse and cleared only by writing 1 to bit 1. Writing 0 leaves it unchanged.
- R4: When a hardware set and a software write-1 clear hit the same change flag in one cycle, the flag ends up set.
- R5: Bit 2 (port enabled) becomes 1 only when a reset-finished pulse arrives while bit 0 is 1, no detach pulse is present and overcurrent is inactive. Writing 1 to bit 2 clears it. Software cannot set it.
- R6: A detach pulse clears bit 0 and bit 2 in the same following cycle.
- R7: Bit 3 (enable changed) is set in the same cycle that bit 2 changes value for any reason, and is cleared by writing 1 to bit 3.
- R8: Bit 4 follows the overcurrent input one cycle late. Bit 5 is set whenever that input differs from bit 4 and is cleared by writing 1 to bit 5. Overcurrent active clears bit 2.
- R9: Bits 6 (resume), 7 (suspend), 8 (port reset), 12 (power) and 16:13 (test control) are read/write. They drive `port_resume_o`, `port_susp_o`, `port_rst_o`, `port_pwr_o` and `port_test_o`.
- R10: Bits 11:10 show the line state and bits 18:17 the speed code (0 high, 1 full, 2 low), each captured one cycle after the input. Bits 9 and 31:19 read 0.
- R11: `port_irq_o` equals the OR of bits 1, 3 and 5, valid in the same cycle as those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Full-word write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current register image |
| conn_evt | input | 1 | One-cycle pulse: device attached |
| disc_evt | input | 1 | One-cycle pulse: device detached |
| ovc_lvl | input | 1 | Overcurrent level, high while active |
| rst_done | input | 1 | One-cycle pulse: port reset sequence finished |
| line_st | input | 2 | Line state from sampling logic |
| spd_code | input | 2 | Detected speed code |
| port_rst_o | output | 1 | Port reset drive |
| port_pwr_o | output | 1 | Port power drive |
| port_susp_o | output | 1 | Suspend drive |
| port_resume_o | output | 1 | Resume signalling drive |
| port_test_o | output | 4 | Test-control selection |
| port_irq_o | output | 1 | Port interrupt |

## Verification
The properties assume that `conn_evt`, `disc_evt` and `rst_done` are single-cycle pulses sampled on the clock. They also assume all inputs hold a defined value while reset is asserted, because enable and change checks compare against the value from the previous cycle. The stimulus drives every input on the falling edge, so it is stable at the rising edge. It keeps the level inputs at zero during reset. Pulses are generated as one-cycle events, including random phases where attach, detach, reset-finished and overcurrent changes collide with write-1 clears.

// File: rtl/hport_pkg.sv
package hport_pkg;
  localparam int CSR_W  = 32;
  localparam int LINE_W = 2;
  localparam int SPD_W  = 2;
  localparam int TST_W  = 4;

  // Bit positions decoded by host software.
  localparam int P_CONN = 0;
  localparam int P_CDET = 1;
  localparam int P_EN   = 2;
  localparam int P_ECHG = 3;
  localparam int P_OCA  = 4;
  localparam int P_OCHG = 5;
  localparam int P_RESM = 6;
  localparam int P_SUSP = 7;
  localparam int P_PRST = 8;
  localparam int P_LINE = 10;
  localparam int P_PWR  = 12;
  localparam int P_TST  = 13;
  localparam int P_SPD  = 17;

  // Sticky change flags, in slot order.
  localparam int N_CHG   = 3;
  localparam int CHG_CON = 0;
  localparam int CHG_EN  = 1;
  localparam int CHG_OC  = 2;

  typedef struct packed {
    logic             resume;
    logic             suspend;
    logic             prst;
    logic             pwr;
    logic [TST_W-1:0] tst;
  } port_ctl_t;
endpackage

// File: rtl/hport_w1c.sv
// Bank of sticky flags: hardware sets, software clears by writing one.
// A set in the same cycle as a clear leaves the flag set.
module hport_w1c #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] q;

  always_comb nxt_o = (q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  assign q_o = q;
endmodule

// File: rtl/hport_enable.sv
// Connection status and hardware-owned port enable.
module hport_enable (
  input  logic clk,
  input  logic rst,
  input  logic attach_i,
  input  logic detach_i,
  input  logic ovc_i,
  input  logic rst_fin_i,
  input  logic sw_clr_i,
  output logic conn_o,
  output logic en_o,
  output logic en_flip_o
);
  logic conn_q, conn_d;
  logic en_q, en_d;

  always_comb begin
    conn_d = conn_q;
    if (attach_i) conn_d = 1'b1;
    if (detach_i) conn_d = 1'b0;

    en_d = en_q;
    if (sw_clr_i || ovc_i || detach_i) en_d = 1'b0;
    if (rst_fin_i && conn_q && !detach_i && !ovc_i) en_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      conn_q <= conn_d;
      en_q   <= en_d;
    end
  end

  assign conn_o    = conn_q;
  assign en_o      = en_q;
  assign en_flip_o = en_d ^ en_q;
endmodule

// File: rtl/hport_ctrl.sv
// Software control fields and captured status levels.
module hport_ctrl
  import hport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  port_ctl_t         wctl_i,
  input  logic              ovc_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [SPD_W-1:0]  spd_i,
  output port_ctl_t         ctl_o,
  output logic              ovc_o,
  output logic [LINE_W-1:0] line_o,
  output logic [SPD_W-1:0]  spd_o
);
  port_ctl_t         ctl_q;
  logic              ovc_q;
  logic [LINE_W-1:0] line_q;
  logic [SPD_W-1:0]  spd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      ovc_q  <= 1'b0;
      line_q <= '0;
      spd_q  <= '0;
    end else begin
      if (we_i) ctl_q <= wctl_i;
      ovc_q  <= ovc_i;
      line_q <= line_i;
      spd_q  <= spd_i;
    end
  end

  assign ctl_o  = ctl_q;
  assign ovc_o  = ovc_q;
  assign line_o = line_q;
  assign spd_o  = spd_q;
endmodule

// File: rtl/hport_csr.sv
module hport_csr
  import hport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  input  logic              conn_evt,
  input  logic              disc_evt,
  input  logic              ovc_lvl,
  input  logic              rst_done,
  input  logic [LINE_W-1:0] line_st,
  input  logic [SPD_W-1:0]  spd_code,
  output logic              port_rst_o,
  output logic              port_pwr_o,
  output logic              port_susp_o,
  output logic              port_resume_o,
  output logic [TST_W-1:0]  port_test_o,
  output logic              port_irq_o
);
  localparam int CHG_POS [N_CHG] = '{P_CDET, P_ECHG, P_OCHG};

  logic              conn, en, en_flip;
  logic              ovc_q;
  logic [LINE_W-1:0] line_q;
  logic [SPD_W-1:0]  spd_q;
  port_ctl_t         ctl, wctl;
  logic [N_CHG-1:0]  chg_set, chg_clr, chg_q, chg_nxt;
  logic              irq_q;
  logic              unused_wbits;

  assign unused_wbits = ^{csr_wdata[CSR_W-1:P_SPD], csr_wdata[P_LINE+LINE_W-1:P_PRST+1],
                          csr_wdata[P_OCA], csr_wdata[P_CONN]};

  assign wctl.resume  = csr_wdata[P_RESM];
  assign wctl.suspend = csr_wdata[P_SUSP];
  assign wctl.prst    = csr_wdata[P_PRST];
  assign wctl.pwr     = csr_wdata[P_PWR];
  assign wctl.tst     = csr_wdata[P_TST +: TST_W];

  hport_enable u_en (
    .clk       (clk),
    .rst       (rst),
    .attach_i  (conn_evt),
    .detach_i  (disc_evt),
    .ovc_i     (ovc_lvl),
    .rst_fin_i (rst_done),
    .sw_clr_i  (csr_we & csr_wdata[P_EN]),
    .conn_o    (conn),
    .en_o      (en),
    .en_flip_o (en_flip)
  );

  hport_ctrl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .we_i   (csr_we),
    .wctl_i (wctl),
    .ovc_i  (ovc_lvl),
    .line_i (line_st),
    .spd_i  (spd_code),
    .ctl_o  (ctl),
    .ovc_o  (ovc_q),
    .line_o (line_q),
    .spd_o  (spd_q)
  );

  always_comb begin
    chg_set          = '0;
    chg_set[CHG_CON] = conn_evt;
    chg_set[CHG_EN]  = en_flip;
    chg_set[CHG_OC]  = ovc_lvl ^ ovc_q;
  end

  for (genvar i = 0; i < N_CHG; i++) begin : g_clr
    assign chg_clr[i] = csr_we & csr_wdata[CHG_POS[i]];
  end

  hport_w1c #(.W(N_CHG)) u_chg (
    .clk   (clk),
    .rst   (rst),
    .set_i (chg_set),
    .clr_i (chg_clr),
    .q_o   (chg_q),
    .nxt_o (chg_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |chg_nxt;
  end

  always_comb begin
    csr_rdata                    = '0;
    csr_rdata[P_CONN]            = conn;
    csr_rdata[P_EN]              = en;
    csr_rdata[P_OCA]             = ovc_q;
    csr_rdata[P_RESM]            = ctl.resume;
    csr_rdata[P_SUSP]            = ctl.suspend;
    csr_rdata[P_PRST]            = ctl.prst;
    csr_rdata[P_PWR]             = ctl.pwr;
    csr_rdata[P_TST +: TST_W]    = ctl.tst;
    csr_rdata[P_LINE +: LINE_W]  = line_q;
    csr_rdata[P_SPD +: SPD_W]    = spd_q;
    for (int i = 0; i < N_CHG; i++) csr_rdata[CHG_POS[i]] = chg_q[i];
  end

  assign port_rst_o    = ctl.prst;
  assign port_pwr_o    = ctl.pwr;
  assign port_susp_o   = ctl.suspend;
  assign port_resume_o = ctl.resume;
  assign port_test_o   = ctl.tst;
  assign port_irq_o    = irq_q;
endmodule

// File: rtl/hport_csr_chk.sv
module hport_csr_chk
  import hport_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             conn_evt,
  input logic             disc_evt,
  input logic             rst_done,
  input logic [CSR_W-1:0] csr_rdata,
  input logic             port_irq_o
);
  AST_CONN_NEEDS_ATTACH: assert property (@(posedge clk) disable iff (rst)
    $rose(csr_rdata[P_CONN]) |-> $past(conn_evt)); // R2
  AST_CDET_ON_ATTACH: assert property (@(posedge clk) disable iff (rst)
    conn_evt |=> csr_rdata[P_CDET]); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    conn_evt |=> port_irq_o); // R4
  AST_EN_FROM_HW: assert property (@(posedge clk) disable iff (rst)
    $rose(csr_rdata[P_EN]) |-> $past(rst_done)); // R5
  AST_DETACH_DROPS: assert property (@(posedge clk) disable iff (rst)
    disc_evt |=> (!csr_rdata[P_CONN] && !csr_rdata[P_EN])); // R6
  AST_ECHG_ON_FLIP: assert property (@(posedge clk) disable iff (rst)
    (csr_rdata[P_EN] != $past(csr_rdata[P_EN])) |-> csr_rdata[P_ECHG]); // R7
  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
    port_irq_o == (csr_rdata[P_CDET] | csr_rdata[P_ECHG] | csr_rdata[P_OCHG])); // R11
endmodule

bind hport_csr hport_csr_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .conn_evt   (conn_evt),
  .disc_evt   (disc_evt),
  .rst_done   (rst_done),
  .csr_rdata  (csr_rdata),
  .port_irq_o (port_irq_o)
);

// File: tb/hport_csr_test.sv
`timescale 1ns/1ps
module hport_csr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        conn_evt = 1'b0, disc_evt = 1'b0, ovc_lvl = 1'b0, rst_done = 1'b0;
  logic [1:0]  line_st = '0, spd_code = '0;
  logic        port_rst_o, port_pwr_o, port_susp_o, port_resume_o, port_irq_o;
  logic [3:0]  port_test_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hport_csr uut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .conn_evt(conn_evt), .disc_evt(disc_evt), .ovc_lvl(ovc_lvl), .rst_done(rst_done),
    .line_st(line_st), .spd_code(spd_code), .port_rst_o(port_rst_o), .port_pwr_o(port_pwr_o),
    .port_susp_o(port_susp_o), .port_resume_o(port_resume_o), .port_test_o(port_test_o),
    .port_irq_o(port_irq_o)
  );

  // Behavioural reference: one variable per visible field.
  bit m_conn, m_cdet, m_en, m_echg, m_oca, m_ochg, m_res, m_sus, m_prst, m_pwr, m_irq;
  int m_tst, m_line, m_spd;

  always @(posedge clk) begin
    bit old_en;
    if (rst) begin
      m_conn = 0; m_cdet = 0; m_en = 0; m_echg = 0; m_oca = 0; m_ochg = 0;
      m_res = 0; m_sus = 0; m_prst = 0; m_pwr = 0; m_irq = 0;
      m_tst = 0; m_line = 0; m_spd = 0;
    end else begin
      old_en = m_en;
      if (csr_we && csr_wdata[2]) m_en = 0;
      if (ovc_lvl || disc_evt) m_en = 0;
      if (rst_done && m_conn && !disc_evt && !ovc_lvl) m_en = 1;
      if (csr_we && csr_wdata[1]) m_cdet = 0;
      if (conn_evt) m_cdet = 1;
      if (csr_we && csr_wdata[3]) m_echg = 0;
      if (old_en != m_en) m_echg = 1;
      if (csr_we && csr_wdata[5]) m_ochg = 0;
      if (ovc_lvl != m_oca) m_ochg = 1;
      m_oca = ovc_lvl;
      if (conn_evt) m_conn = 1;
      if (disc_evt) m_conn = 0;
      if (csr_we) begin
        m_res = csr_wdata[6]; m_sus = csr_wdata[7]; m_prst = csr_wdata[8];
        m_pwr = csr_wdata[12]; m_tst = int'(csr_wdata[16:13]);
      end
      m_line = int'(line_st);
      m_spd  = int'(spd_code);
      m_irq  = m_cdet | m_echg | m_ochg;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Field-by-field comparison against the model on every falling edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 conn",   32'(csr_rdata[0]), 32'(m_conn));
      chk("R3 cdet",   32'(csr_rdata[1]), 32'(m_cdet));
      chk("R5 enable", 32'(csr_rdata[2]), 32'(m_en));
      chk("R7 echg",   32'(csr_rdata[3]), 32'(m_echg));
      chk("R8 oc",     32'(csr_rdata[5:4]), {30'd0, m_ochg, m_oca});
      chk("R9 ctl",    {port_test_o, port_pwr_o, port_rst_o, port_susp_o, port_resume_o},
                       {m_tst[3:0], m_pwr, m_prst, m_sus, m_res});
      chk("R9 ctlbits", {csr_rdata[16:12], csr_rdata[8:6]},
                        {m_tst[3:0], m_pwr, m_prst, m_sus, m_res});
      chk("R10 status", {csr_rdata[31:17], csr_rdata[11:9]},
                        {13'd0, m_spd[1:0], m_line[1:0], 1'b0});
      chk("R11 irq",   32'(port_irq_o), 32'(m_irq));
    end
  end

  // Drive one cycle of stimulus from a falling edge; pulses last one cycle.
  task automatic cyc(input bit c, input bit d, input bit rd, input bit we, input logic [31:0] wd);
    conn_evt = c; disc_evt = d; rst_done = rd; csr_we = we; csr_wdata = wd;
    @(negedge clk);
    conn_evt = 0; disc_evt = 0; rst_done = 0; csr_we = 0; csr_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cyc(0, 0, 0, 0, 0);
    chk("R1 reset word", csr_rdata, 32'h0);
    chk("R1 reset outs", {port_irq_o, port_rst_o, port_pwr_o, port_susp_o, port_resume_o, port_test_o}, 0);

    cyc(0, 0, 0, 1, 32'hFFFF_FFFF);
    chk("R9 R2 R5 write ones", csr_rdata, 32'h0001_F1C0);
    chk("R9 drives", {port_test_o, port_pwr_o, port_rst_o, port_susp_o, port_resume_o}, 8'hFF);
    cyc(0, 0, 0, 1, 0);

    cyc(1, 0, 0, 0, 0);
    chk("R2 R3 attach", csr_rdata[1:0], 2'b11);
    chk("R11 irq attach", 32'(port_irq_o), 1);
    cyc(0, 0, 0, 1, 32'h0);
    chk("R3 write0 keeps", 32'(csr_rdata[1]), 1);
    cyc(0, 0, 0, 1, 32'h2);
    chk("R3 w1c", 32'(csr_rdata[1]), 0);
    chk("R11 irq idle", 32'(port_irq_o), 0);

    cyc(1, 0, 0, 1, 32'h2);
    chk("R4 set wins", 32'(csr_rdata[1]), 1);
    cyc(0, 0, 0, 1, 32'h2);

    cyc(0, 0, 1, 0, 0);
    chk("R5 R7 enable by hw", csr_rdata[3:2], 2'b11);
    cyc(0, 0, 0, 1, 32'h8);
    cyc(0, 0, 0, 1, 32'h4);
    chk("R5 R7 sw clear en", csr_rdata[3:2], 2'b10);
    cyc(0, 0, 0, 1, 32'h8);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 32'h8);

    ovc_lvl = 1;
    cyc(0, 0, 0, 0, 0);
    chk("R8 oc on", csr_rdata[5:2], 4'b1110);
    cyc(0, 0, 0, 1, 32'h28);
    ovc_lvl = 0;
    cyc(0, 0, 0, 0, 0);
    chk("R8 oc off", csr_rdata[5:4], 2'b10);
    cyc(0, 0, 0, 1, 32'h20);

    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 32'h8);
    cyc(0, 1, 0, 0, 0);
    chk("R6 detach", csr_rdata[3:0], 4'b1000);
    cyc(0, 0, 0, 1, 32'h8);
    cyc(0, 0, 1, 0, 0);
    chk("R5 no enable disconnected", 32'(csr_rdata[2]), 0);

    for (int s = 0; s < 3; s++) begin
      line_st = 2'(s + 1); spd_code = 2'(s);
      cyc(0, 0, 0, 0, 0);
      chk("R10 line speed", {csr_rdata[18:17], csr_rdata[11:10]}, {2'(s), 2'(s + 1)});
    end

    for (int n = 0; n < 2000; n++) begin
      if (($urandom % 8) == 0) ovc_lvl = ~ovc_lvl;
      line_st = 2'($urandom); spd_code = 2'($urandom % 3);
      cyc(($urandom % 6) == 0, ($urandom % 9) == 0, ($urandom % 3) == 0,
          ($urandom % 3) == 0, $urandom);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule